// File: doc/BRIEF.md
# Indirect Sub-Addressed Control Register Bank

This block is the host-facing control register bank of a network controller. A host reaches it through a small parallel bus: a 3-bit address, a write strobe with 8-bit write data, and a read strobe that returns 8-bit read data on the next cycle. Three addresses are decoded. One holds a sub-address pointer. One holds the configuration byte. The third is a window whose target is picked by the pointer. Through the window the host reaches the tentative ID, node ID, first setup, next ID and second setup registers.

The two low pointer bits are one storage element. It is visible both in the pointer register and in the configuration byte. Any configuration write forces the top pointer bit to zero. The configuration byte carries three controls:
- a software reset, held for as long as its bit stays set;
- a command chaining enable;
- a transmit enable, which gates the line driver outputs.

The next ID register is loaded by the protocol engine through a load strobe. The host can read it but cannot write it. While the software reset is held, the next ID register is cleared and its loads are refused. Every other register in the bank keeps its value.

Top module: `netctl_regbank`

## Requirements
- R1: A synchronous hardware reset (`rst` high at a clock edge) clears the pointer, the configuration byte, all window registers, the read data and all driver outputs to zero.
- R2: A write to address 5 stores write-data bits 2:0 as the 3-bit pointer. A read of address 5 returns the pointer in bits 2:0 and zero in bits 7:3.
- R3: A window access at address 7 reaches the register chosen by the pointer: 000 tentative ID, 001 node ID, 010 setup 1, 100 setup 2. Each stores and returns all 8 bits.
- R4: Pointer bits 1:0 are one shared element. A configuration write (address 6) loads them from write-data bits 1:0. A read of address 6 returns them in bits 1:0.
- R5: Every write to address 6 clears pointer bit 2.
- R6: With pointer 101, 110 or 111, a window read returns 0x00 and a window write changes no register.
- R7: Pointer 011 shows the next ID. It loads from `next_id_in` at an edge where `next_id_load` is high and the software reset is not held. Window writes to it are discarded.
- R8: Configuration bit 7 is the software reset and drives `soft_rst_o`. While it is 1, the next ID reads 0x00 and refuses loads. The configuration byte and the other window registers are unaffected. It ends only when 0 is written back to bit 7.
- R9: Configuration bit 6 is the chaining enable and drives `chain_en_o`.
- R10: Configuration bit 5 is the transmit enable. One cycle after the inputs are sampled, `tx_drive_o` equals `tx_req_i` AND the transmit enable. Each `pulse_o` bit equals its `pulse_raw_i` bit AND the transmit enable, except in backplane mode, where it passes ungated.
- R11: `bus_rdata` changes only on the clock edge that samples `bus_rd`, with the addressed value. Addresses 0 to 4 read 0x00. Configuration bits 4:2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_addr | input | 3 | Host register address |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered host read data |
| next_id_in | input | 8 | Next ID value from the protocol engine |
| next_id_load | input | 1 | Load strobe for the next ID |
| backplane_i | input | 1 | Backplane mode: pulse outputs not gated |
| pulse_raw_i | input | 2 | Ungated line pulse requests |
| tx_req_i | input | 1 | Ungated transmit-enable request |
| soft_rst_o | output | 1 | Software reset level |
| chain_en_o | output | 1 | Command chaining enable |
| pulse_o | output | 2 | Gated line pulses (registered) |
| tx_drive_o | output | 1 | Gated transmit-enable pin (registered) |

## Verification
The bench builds the block with its default parameters: 8-bit data, a 3-bit pointer with 2 shared low bits, five window slots with the read-only slot at code 3, and two pulse lines. With these values all eight pointer codes can be driven. So every populated slot and all three reserved codes are reached. The write that clears the top pointer bit is checked against a pointer that had that bit set. Both pulse lines are seen gated and ungated across the backplane and transmit-enable combinations.

// File: rtl/netreg_pkg.sv
package netreg_pkg;
  // configuration byte bit positions (host-visible, decoded by software)
  localparam int unsigned CFG_RST_BIT   = 7;
  localparam int unsigned CFG_CHAIN_BIT = 6;
  localparam int unsigned CFG_TXEN_BIT  = 5;
  // pointer bits shared between the pointer register and the config byte
  localparam int unsigned SHARED_W      = 2;

  typedef enum logic [2:0] {
    SLOT_TENT   = 3'd0,
    SLOT_NODE   = 3'd1,
    SLOT_SETUP1 = 3'd2,
    SLOT_NEXT   = 3'd3,
    SLOT_SETUP2 = 3'd4
  } slot_e;
endpackage

// File: rtl/netreg_subaddr.sv
module netreg_subaddr #(
  parameter int unsigned SUB_W  = 3,
  parameter int unsigned LOW_W  = netreg_pkg::SHARED_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ptr,
  input  logic             wr_cfg,
  input  logic [SUB_W-1:0] ptr_d,
  input  logic [LOW_W-1:0] low_d,
  output logic [SUB_W-1:0] ptr_o
);
  localparam int unsigned HIGH_W = SUB_W - LOW_W;

  logic [LOW_W-1:0]  low_q;
  logic [HIGH_W-1:0] high_q;

  // shared low bits: single storage element, two write paths
  always_ff @(posedge clk) begin
    if (rst) begin
      low_q <= '0;
    end else if (wr_cfg) begin
      low_q <= low_d;
    end else if (wr_ptr) begin
      low_q <= ptr_d[LOW_W-1:0];
    end
  end

  // high bits: cleared by any configuration write
  always_ff @(posedge clk) begin
    if (rst) begin
      high_q <= '0;
    end else if (wr_cfg) begin
      high_q <= '0;
    end else if (wr_ptr) begin
      high_q <= ptr_d[SUB_W-1:LOW_W];
    end
  end

  assign ptr_o = {high_q, low_q};
endmodule

// File: rtl/netreg_cfg.sv
module netreg_cfg (
  input  logic clk,
  input  logic rst,
  input  logic wr_cfg,
  input  logic srst_d,
  input  logic chain_d,
  input  logic txen_d,
  output logic srst_o,
  output logic chain_o,
  output logic txen_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      srst_o  <= 1'b0;
      chain_o <= 1'b0;
      txen_o  <= 1'b0;
    end else if (wr_cfg) begin
      srst_o  <= srst_d;
      chain_o <= chain_d;
      txen_o  <= txen_d;
    end
  end
endmodule

// File: rtl/netreg_window.sv
module netreg_window #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SUB_W    = 3,
  parameter int unsigned NUM_SLOT = 5,
  parameter int unsigned RO_SLOT  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_win,
  input  logic [SUB_W-1:0]           ptr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       srst,
  input  logic                       nid_load,
  input  logic [DATA_W-1:0]          nid_in,
  output logic [DATA_W-1:0]          rd_o,
  output logic [NUM_SLOT*DATA_W-1:0] slots_o
);
  for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot
    logic [DATA_W-1:0] q;
    if (k == RO_SLOT) begin : g_ro
      // engine-loaded, host read-only, cleared while soft reset is held
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= '0;
        end else if (srst) begin
          q <= '0;
        end else if (nid_load) begin
          q <= nid_in;
        end
      end
    end else begin : g_rw
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= '0;
        end else if (wr_win && ptr == SUB_W'(k)) begin
          q <= wdata;
        end
      end
    end
    assign slots_o[k*DATA_W +: DATA_W] = q;
  end

  // pointer codes at or above NUM_SLOT select nothing and read zero
  always_comb begin
    rd_o = '0;
    for (int k = 0; k < NUM_SLOT; k++) begin
      if (ptr == SUB_W'(k)) begin
        rd_o = slots_o[k*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/netreg_txgate.sv
module netreg_txgate #(
  parameter int unsigned NUM_PULSE = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 txen,
  input  logic                 backplane,
  input  logic [NUM_PULSE-1:0] pulse_raw,
  input  logic                 tx_req,
  output logic [NUM_PULSE-1:0] pulse_o,
  output logic                 tx_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_o <= 1'b0;
    end else begin
      tx_o <= tx_req & txen;
    end
  end

  for (genvar p = 0; p < NUM_PULSE; p++) begin : g_pulse
    always_ff @(posedge clk) begin
      if (rst) begin
        pulse_o[p] <= 1'b0;
      end else begin
        pulse_o[p] <= pulse_raw[p] & (txen | backplane);
      end
    end
  end
endmodule

// File: rtl/netctl_regbank.sv
module netctl_regbank #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned SUB_W     = 3,
  parameter int unsigned NUM_SLOT  = 5,
  parameter int unsigned NUM_PULSE = 2,
  parameter int unsigned PTR_ADDR  = 5,
  parameter int unsigned CFG_ADDR  = 6,
  parameter int unsigned WIN_ADDR  = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [DATA_W-1:0]    next_id_in,
  input  logic                 next_id_load,
  input  logic                 backplane_i,
  input  logic [NUM_PULSE-1:0] pulse_raw_i,
  input  logic                 tx_req_i,
  output logic                 soft_rst_o,
  output logic                 chain_en_o,
  output logic [NUM_PULSE-1:0] pulse_o,
  output logic                 tx_drive_o
);
  import netreg_pkg::*;

  localparam int unsigned LOW_W   = SHARED_W;
  localparam int unsigned RO_SLOT = int'(SLOT_NEXT);

  logic                       wr_ptr, wr_cfg, wr_win;
  logic [SUB_W-1:0]           sub_q;
  logic                       cfg_txen;
  logic [DATA_W-1:0]          win_rd;
  logic [NUM_SLOT*DATA_W-1:0] win_flat;
  logic [DATA_W-1:0]          next_id_q;
  logic [DATA_W-1:0]          rd_mux;
  logic [DATA_W-1:0]          rdata_q;

  assign wr_ptr = bus_wr && (bus_addr == ADDR_W'(PTR_ADDR));
  assign wr_cfg = bus_wr && (bus_addr == ADDR_W'(CFG_ADDR));
  assign wr_win = bus_wr && (bus_addr == ADDR_W'(WIN_ADDR));

  netreg_subaddr #(.SUB_W(SUB_W), .LOW_W(LOW_W)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .wr_ptr(wr_ptr),
    .wr_cfg(wr_cfg),
    .ptr_d (bus_wdata[SUB_W-1:0]),
    .low_d (bus_wdata[LOW_W-1:0]),
    .ptr_o (sub_q)
  );

  netreg_cfg u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr_cfg (wr_cfg),
    .srst_d (bus_wdata[CFG_RST_BIT]),
    .chain_d(bus_wdata[CFG_CHAIN_BIT]),
    .txen_d (bus_wdata[CFG_TXEN_BIT]),
    .srst_o (soft_rst_o),
    .chain_o(chain_en_o),
    .txen_o (cfg_txen)
  );

  netreg_window #(
    .DATA_W(DATA_W), .SUB_W(SUB_W), .NUM_SLOT(NUM_SLOT), .RO_SLOT(RO_SLOT)
  ) u_win (
    .clk     (clk),
    .rst     (rst),
    .wr_win  (wr_win),
    .ptr     (sub_q),
    .wdata   (bus_wdata),
    .srst    (soft_rst_o),
    .nid_load(next_id_load),
    .nid_in  (next_id_in),
    .rd_o    (win_rd),
    .slots_o (win_flat)
  );

  assign next_id_q = win_flat[RO_SLOT*DATA_W +: DATA_W];

  netreg_txgate #(.NUM_PULSE(NUM_PULSE)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .txen     (cfg_txen),
    .backplane(backplane_i),
    .pulse_raw(pulse_raw_i),
    .tx_req   (tx_req_i),
    .pulse_o  (pulse_o),
    .tx_o     (tx_drive_o)
  );

  // read selection
  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(PTR_ADDR)) begin
      rd_mux[SUB_W-1:0] = sub_q;
    end else if (bus_addr == ADDR_W'(CFG_ADDR)) begin
      rd_mux[CFG_RST_BIT]   = soft_rst_o;
      rd_mux[CFG_CHAIN_BIT] = chain_en_o;
      rd_mux[CFG_TXEN_BIT]  = cfg_txen;
      rd_mux[LOW_W-1:0]     = sub_q[LOW_W-1:0];
    end else if (bus_addr == ADDR_W'(WIN_ADDR)) begin
      rd_mux = win_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/netctl_regbank_chk.sv
module netctl_regbank_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned SUB_W     = 3,
  parameter int unsigned NUM_SLOT  = 5,
  parameter int unsigned NUM_PULSE = 2,
  parameter int unsigned PTR_ADDR  = 5,
  parameter int unsigned CFG_ADDR  = 6,
  parameter int unsigned WIN_ADDR  = 7
) (
  input logic                       clk,
  input logic                       rst,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic                       bus_wr,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic [SUB_W-1:0]           sub_q,
  input logic                       cfg_txen,
  input logic [NUM_SLOT*DATA_W-1:0] win_flat,
  input logic [DATA_W-1:0]          next_id_q,
  input logic [DATA_W-1:0]          next_id_in,
  input logic                       next_id_load,
  input logic                       backplane_i,
  input logic                       soft_rst_o,
  input logic                       chain_en_o,
  input logic [NUM_PULSE-1:0]       pulse_o,
  input logic                       tx_drive_o
);
  import netreg_pkg::*;

  // R2
  ptr_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(PTR_ADDR)) |=> sub_q == $past(bus_wdata[SUB_W-1:0]));

  // R4
  shared_low_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(CFG_ADDR)) |=> sub_q[SHARED_W-1:0] == $past(bus_wdata[SHARED_W-1:0]));

  // R5
  cfg_clears_top_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(CFG_ADDR)) |=> !sub_q[SUB_W-1]);

  // R6
  reserved_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(WIN_ADDR) && sub_q >= SUB_W'(NUM_SLOT)
     && !next_id_load && !soft_rst_o) |=> $stable(win_flat));

  // R7
  next_load_chk: assert property (@(posedge clk) disable iff (rst)
    (next_id_load && !soft_rst_o) |=> next_id_q == $past(next_id_in));

  // R8
  srst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst_o |=> next_id_q == '0);

  // R9
  chain_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(CFG_ADDR)) |=> chain_en_o == $past(bus_wdata[CFG_CHAIN_BIT]));

  // R10
  tx_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_txen |=> !tx_drive_o);

  // R10
  pulse_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg_txen && !backplane_i) |=> pulse_o == '0);
endmodule

bind netctl_regbank netctl_regbank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SUB_W(SUB_W), .NUM_SLOT(NUM_SLOT),
  .NUM_PULSE(NUM_PULSE), .PTR_ADDR(PTR_ADDR), .CFG_ADDR(CFG_ADDR), .WIN_ADDR(WIN_ADDR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .sub_q       (sub_q),
  .cfg_txen    (cfg_txen),
  .win_flat    (win_flat),
  .next_id_q   (next_id_q),
  .next_id_in  (next_id_in),
  .next_id_load(next_id_load),
  .backplane_i (backplane_i),
  .soft_rst_o  (soft_rst_o),
  .chain_en_o  (chain_en_o),
  .pulse_o     (pulse_o),
  .tx_drive_o  (tx_drive_o)
);

// File: tb/netctl_regbank_bench.sv
`timescale 1ns/1ps
module netctl_regbank_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic [7:0] next_id_in;
  logic       next_id_load;
  logic       backplane_i;
  logic [1:0] pulse_raw_i;
  logic       tx_req_i;
  logic       soft_rst_o, chain_en_o, tx_drive_o;
  logic [1:0] pulse_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  netctl_regbank u_netctl_regbank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .next_id_in(next_id_in),
    .next_id_load(next_id_load), .backplane_i(backplane_i), .pulse_raw_i(pulse_raw_i),
    .tx_req_i(tx_req_i), .soft_rst_o(soft_rst_o), .chain_en_o(chain_en_o),
    .pulse_o(pulse_o), .tx_drive_o(tx_drive_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic load_nid(input logic [7:0] v);
    next_id_in = v; next_id_load = 1'b1;
    tick();
    next_id_load = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 soft_rst", {7'd0, soft_rst_o}, 8'h00);
    check("R1 chain", {7'd0, chain_en_o}, 8'h00);
    check("R1 tx_drive", {7'd0, tx_drive_o}, 8'h00);
    check("R1 rdata", bus_rdata, 8'h00);
    rd(3'd5, v); check("R1 ptr", v, 8'h00);
    rd(3'd6, v); check("R1 cfg", v, 8'h00);
    rd(3'd7, v); check("R1 tentative", v, 8'h00);
  endtask

  task automatic t_ptr();
    logic [7:0] v;
    wr(3'd5, 8'hFC);
    rd(3'd5, v); check("R2 ptr upper bits", v, 8'h04);
    wr(3'd5, 8'h02);
    rd(3'd5, v); check("R2 ptr value", v, 8'h02);
  endtask

  task automatic t_window();
    logic [7:0] v;
    wr(3'd5, 8'h00); wr(3'd7, 8'h11);
    wr(3'd5, 8'h01); wr(3'd7, 8'h22);
    wr(3'd5, 8'h02); wr(3'd7, 8'h33);
    wr(3'd5, 8'h04); wr(3'd7, 8'h55);
    wr(3'd5, 8'h00); rd(3'd7, v); check("R3 tentative", v, 8'h11);
    wr(3'd5, 8'h01); rd(3'd7, v); check("R3 node", v, 8'h22);
    wr(3'd5, 8'h02); rd(3'd7, v); check("R3 setup1", v, 8'h33);
    wr(3'd5, 8'h04); rd(3'd7, v); check("R3 setup2", v, 8'h55);
    rd(3'd2, v); check("R11 unused address", v, 8'h00);
  endtask

  task automatic t_shared();
    logic [7:0] v;
    wr(3'd5, 8'h04);
    wr(3'd6, 8'h1F);
    rd(3'd5, v); check("R5 top bit cleared", v, 8'h03);
    rd(3'd6, v); check("R11 cfg reserved bits", v, 8'h03);
    wr(3'd5, 8'h01);
    rd(3'd6, v); check("R4 cfg shows ptr low", v, 8'h01);
    wr(3'd6, 8'h00);
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    for (int s = 5; s < 8; s++) begin
      wr(3'd5, 8'(s));
      wr(3'd7, 8'hAA);
      rd(3'd7, v); check("R6 reserved read", v, 8'h00);
    end
    wr(3'd5, 8'h00); rd(3'd7, v); check("R6 tentative kept", v, 8'h11);
    wr(3'd5, 8'h01); rd(3'd7, v); check("R6 node kept", v, 8'h22);
    wr(3'd5, 8'h02); rd(3'd7, v); check("R6 setup1 kept", v, 8'h33);
    wr(3'd5, 8'h04); rd(3'd7, v); check("R6 setup2 kept", v, 8'h55);
  endtask

  task automatic t_nextid();
    logic [7:0] v;
    load_nid(8'h5A);
    wr(3'd5, 8'h03);
    rd(3'd7, v); check("R7 next id load", v, 8'h5A);
    wr(3'd7, 8'hFF);
    rd(3'd7, v); check("R7 next id read-only", v, 8'h5A);
  endtask

  task automatic t_softreset();
    logic [7:0] v;
    wr(3'd6, 8'h83);
    check("R8 soft_rst_o set", {7'd0, soft_rst_o}, 8'h01);
    tick();
    rd(3'd7, v); check("R8 next id cleared", v, 8'h00);
    load_nid(8'h77);
    rd(3'd7, v); check("R8 load refused", v, 8'h00);
    rd(3'd6, v); check("R8 cfg kept", v, 8'h83);
    wr(3'd5, 8'h00);
    rd(3'd7, v); check("R8 tentative kept", v, 8'h11);
    check("R8 still held", {7'd0, soft_rst_o}, 8'h01);
    wr(3'd6, 8'h00);
    check("R8 released", {7'd0, soft_rst_o}, 8'h00);
    load_nid(8'h77);
    wr(3'd5, 8'h03);
    rd(3'd7, v); check("R8 load after release", v, 8'h77);
  endtask

  task automatic t_chain();
    wr(3'd6, 8'h40);
    check("R9 chain on", {7'd0, chain_en_o}, 8'h01);
    wr(3'd6, 8'h00);
    check("R9 chain off", {7'd0, chain_en_o}, 8'h00);
  endtask

  task automatic t_txgate();
    pulse_raw_i = 2'b11; tx_req_i = 1'b1; backplane_i = 1'b0;
    tick();
    check("R10 tx gated", {7'd0, tx_drive_o}, 8'h00);
    check("R10 pulses gated", {6'd0, pulse_o}, 8'h00);
    backplane_i = 1'b1;
    tick();
    check("R10 backplane pulses pass", {6'd0, pulse_o}, 8'h03);
    check("R10 backplane tx gated", {7'd0, tx_drive_o}, 8'h00);
    backplane_i = 1'b0;
    wr(3'd6, 8'h20);
    pulse_raw_i = 2'b10;
    tick();
    check("R10 tx passes", {7'd0, tx_drive_o}, 8'h01);
    check("R10 pulses pass", {6'd0, pulse_o}, 8'h02);
    pulse_raw_i = 2'b00; tx_req_i = 1'b0;
  endtask

  task automatic t_hwreset();
    logic [7:0] v;
    wr(3'd6, 8'hE3);
    do_reset();
    check("R1 hw reset soft_rst", {7'd0, soft_rst_o}, 8'h00);
    rd(3'd6, v); check("R1 hw reset cfg", v, 8'h00);
    rd(3'd5, v); check("R1 hw reset ptr", v, 8'h00);
    rd(3'd7, v); check("R1 hw reset window", v, 8'h00);
  endtask

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    next_id_in = '0; next_id_load = 1'b0; backplane_i = 1'b0;
    pulse_raw_i = '0; tx_req_i = 1'b0;
    @(negedge clk);
    do_reset();
    t_reset();
    t_ptr();
    t_window();
    t_shared();
    t_reserved();
    t_nextid();
    t_softreset();
    t_chain();
    t_txgate();
    t_hwreset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule